// File: doc/BRIEF.md
# Indexed Pixel Pipeline with Cursor Overlay

This block turns a stream of raster coordinates into colored pixels for an 8-bit indexed display. For each valid coordinate it issues a frame-buffer byte address. The byte that comes back from video memory selects an entry in a 256-entry color table. A 64×64 hardware cursor is laid over that image. Each cursor pixel is a two-bit code taken from packed 16-bit pattern words. A code of zero lets the frame-buffer color through, and any other code picks one of three cursor colors.

A control word sets the rest of the behaviour. It can force the whole screen black, turn the cursor off, and select the pixel depth. The indexed path works only for the 8-bit depth code. For any other depth the output is black. When the last pixel of a frame leaves the pipeline, the block raises a frame interrupt. The interrupt stays high until a host register write or a reset clears it.

The color table, the cursor colors and the cursor pattern are stored inside the block and are written through simple write strobes. The raster timing generator and the video memory sit outside it.

Top module: `idxpix_cursor_pipe`

## Requirements
- R1: `out_valid`, `out_x` and `out_y` repeat `pix_valid`, `pix_x` and `pix_y` from two clock edges earlier, so each color lines up with its own coordinates. `out_rgb` is zero whenever `out_valid` is low.
- R2: One edge after a valid pixel, `fb_rd` is high and `fb_addr` equals `top_addr + pix_y*scr_width + pix_x`, with no padding between lines. `fb_data` must return the addressed byte while `fb_rd` is high.
- R3: Outside the cursor, `out_rgb` is the color-table entry selected by `fb_data`. Colors are packed red in [23:16], green in [15:8] and blue in [7:0].
- R4: The cursor origin has X in `cur_pos[23:12]` and Y in `cur_pos[11:0]`. A pixel is inside the cursor when `cy <= y < cy+64` and `cx <= x < cx+64`. These compares use 13 bits, so a cursor near the right or bottom edge is clipped and never wraps to coordinate 0.
- R5: Inside the cursor, the pattern word index is `(y-cy)*8 + (x-cx)/8`. The code is bits `[2k+1:2k]` of that word, where `k = (x-cx) mod 8`.
- R6: Code 0 shows the frame-buffer color. Codes 1, 2 and 3 show cursor colors 0, 1 and 2.
- R7: When `ctl[23]` is set, no cursor is drawn and every pixel shows its frame-buffer color.
- R8: When `ctl[10]` is set, every output pixel is black, whatever the pattern or the memory holds.
- R9: The depth field is `ctl[22:20]`. Colors are produced only when it holds 3 (8-bit indexed). For any other value the output is black.
- R10: `frame_irq` rises with the output of the pixel at (`scr_width-1`, `scr_height-1`). It then holds until a `host_wr` pulse clears it one edge later. If a set and a clear fall on the same edge, the set wins.
- R11: After reset, `out_valid`, `fb_rd`, `frame_irq` and `out_rgb` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Raster position is valid |
| pix_x | input | 12 | Raster column |
| pix_y | input | 12 | Raster row |
| fb_rd | output | 1 | Frame-buffer read strobe |
| fb_addr | output | 24 | Frame-buffer byte address |
| fb_data | input | 8 | Byte returned for `fb_addr` |
| ctl | input | 32 | Control word (blank, cursor off, depth) |
| cur_pos | input | 24 | Cursor origin, X in [23:12], Y in [11:0] |
| top_addr | input | 24 | Address of the first screen byte |
| scr_width | input | 12 | Visible width in pixels |
| scr_height | input | 12 | Visible height in lines |
| pal_we | input | 1 | Color-table write strobe |
| pal_idx | input | 8 | Color-table entry |
| pal_rgb | input | 24 | Color-table write data |
| cpal_we | input | 1 | Cursor-color write strobe |
| cpal_idx | input | 2 | Cursor color 0..2 |
| cpal_rgb | input | 24 | Cursor-color write data |
| pat_we | input | 1 | Cursor-pattern write strobe |
| pat_idx | input | 9 | Cursor-pattern word |
| pat_word | input | 16 | Cursor-pattern write data |
| host_wr | input | 1 | Host register write, clears the interrupt |
| out_valid | output | 1 | Output pixel valid |
| out_x | output | 12 | Output pixel column |
| out_y | output | 12 | Output pixel row |
| out_rgb | output | 24 | Output color |
| frame_irq | output | 1 | End-of-frame interrupt |

## Verification
Plain frame-buffer probes run with two different base addresses and line widths. This separates a correct address formula from one that swaps the operands or drops the base. Inside the cursor, a pattern word that holds all four codes side by side shows whether the code bits are picked from the right positions and mapped to the right cursor colors. Probes just inside and just outside each edge of the cursor window, together with a cursor placed near column 4095, tell apart an off-by-one compare, a wrapping compare and a correct clipped one. Blanking, cursor-off and depth values other than 3 are driven over points that would otherwise be colored, and a short frame shows the interrupt setting only on its last pixel and then holding until a host write clears it.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef logic [23:0] rgb_t;
  localparam int CTL_BLANK_BIT = 10;
  localparam int CTL_NOCUR_BIT = 23;
  localparam int CTL_DEPTH_LSB = 20;
  localparam logic [2:0] DEPTH_IDX8 = 3'd3;
endpackage

// File: rtl/ipc_addr_gen.sv
module ipc_addr_gen #(
  parameter int COORD_W = 12,
  parameter int ADDR_W  = 24
) (
  input  logic [ADDR_W-1:0]  base,
  input  logic [COORD_W-1:0] width,
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  output logic [ADDR_W-1:0]  addr
);
  logic [ADDR_W-1:0] row_off;

  always_comb begin
    row_off = ADDR_W'(y) * ADDR_W'(width);
    addr    = base + row_off + ADDR_W'(x);
  end
endmodule

// File: rtl/ipc_cursor.sv
module ipc_cursor #(
  parameter int COORD_W  = 12,
  parameter int CUR_SIZE = 64,
  localparam int CUR_LG  = $clog2(CUR_SIZE),
  localparam int IDX_W   = 2 * CUR_LG - 3
) (
  input  logic               clk,
  input  logic               pat_we,
  input  logic [IDX_W-1:0]   pat_idx,
  input  logic [15:0]        pat_word,
  input  logic               enable,
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic [COORD_W-1:0] org_x,
  input  logic [COORD_W-1:0] org_y,
  output logic [1:0]         code
);
  localparam int WORDS = 1 << IDX_W;
  localparam int EXT_W = COORD_W + 1;

  logic [15:0]      pat_mem [WORDS];
  logic [EXT_W-1:0] xe, ye, oxe, oye, dx, dy;
  logic             in_x, in_y;
  logic [IDX_W-1:0] word_sel;
  logic [15:0]      word;

  always_ff @(posedge clk) begin
    if (pat_we) pat_mem[pat_idx] <= pat_word;
  end

  always_comb begin
    xe       = {1'b0, x};
    ye       = {1'b0, y};
    oxe      = {1'b0, org_x};
    oye      = {1'b0, org_y};
    dx       = xe - oxe;
    dy       = ye - oye;
    in_x     = (xe >= oxe) && (xe < oxe + EXT_W'(CUR_SIZE));
    in_y     = (ye >= oye) && (ye < oye + EXT_W'(CUR_SIZE));
    word_sel = {dy[CUR_LG-1:0], dx[CUR_LG-1:3]};
    word     = pat_mem[word_sel];
    code     = (enable && in_x && in_y) ? word[{dx[2:0], 1'b0} +: 2] : 2'b00;
  end
endmodule

// File: rtl/ipc_palette.sv
module ipc_palette #(
  parameter int IDX_W = 8,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             pal_we,
  input  logic [IDX_W-1:0] pal_idx,
  input  ipc_pkg::rgb_t    pal_rgb,
  input  logic             cpal_we,
  input  logic [1:0]       cpal_idx,
  input  ipc_pkg::rgb_t    cpal_rgb,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [1:0]       rd_code,
  output ipc_pkg::rgb_t    rgb
);
  ipc_pkg::rgb_t color_mem [ENTRIES];
  ipc_pkg::rgb_t cur_col [3];

  always_ff @(posedge clk) begin
    if (pal_we) color_mem[pal_idx] <= pal_rgb;
  end

  for (genvar g = 0; g < 3; g++) begin : g_cur_col
    always_ff @(posedge clk) begin
      if (cpal_we && (cpal_idx == 2'(g))) cur_col[g] <= cpal_rgb;
    end
  end

  always_comb begin
    unique case (rd_code)
      2'd1:    rgb = cur_col[0];
      2'd2:    rgb = cur_col[1];
      2'd3:    rgb = cur_col[2];
      default: rgb = color_mem[rd_idx];
    endcase
  end
endmodule

// File: rtl/idxpix_cursor_pipe.sv
module idxpix_cursor_pipe #(
  parameter int COORD_W   = 12,
  parameter int ADDR_W    = 24,
  parameter int PIX_W     = 8,
  parameter int CUR_SIZE  = 64,
  localparam int PAT_IDX_W = 2 * $clog2(CUR_SIZE) - 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pix_valid,
  input  logic [COORD_W-1:0]   pix_x,
  input  logic [COORD_W-1:0]   pix_y,
  output logic                 fb_rd,
  output logic [ADDR_W-1:0]    fb_addr,
  input  logic [PIX_W-1:0]     fb_data,
  input  logic [31:0]          ctl,
  input  logic [2*COORD_W-1:0] cur_pos,
  input  logic [ADDR_W-1:0]    top_addr,
  input  logic [COORD_W-1:0]   scr_width,
  input  logic [COORD_W-1:0]   scr_height,
  input  logic                 pal_we,
  input  logic [PIX_W-1:0]     pal_idx,
  input  logic [23:0]          pal_rgb,
  input  logic                 cpal_we,
  input  logic [1:0]           cpal_idx,
  input  logic [23:0]          cpal_rgb,
  input  logic                 pat_we,
  input  logic [PAT_IDX_W-1:0] pat_idx,
  input  logic [15:0]          pat_word,
  input  logic                 host_wr,
  output logic                 out_valid,
  output logic [COORD_W-1:0]   out_x,
  output logic [COORD_W-1:0]   out_y,
  output logic [23:0]          out_rgb,
  output logic                 frame_irq
);
  import ipc_pkg::*;

  // stage 1: address issue and cursor code
  logic               s1_v_q, s1_v_d;
  logic [COORD_W-1:0] s1_x_q, s1_x_d, s1_y_q, s1_y_d;
  logic [1:0]         s1_code_q, s1_code_d;
  logic               s1_last_q, s1_last_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  // stage 2: color output
  logic               o_v_d;
  logic [COORD_W-1:0] o_x_d, o_y_d;
  rgb_t               o_rgb_d;
  logic               irq_d;

  logic [ADDR_W-1:0]  calc_addr;
  logic [1:0]         calc_code;
  rgb_t               lut_rgb;
  logic               cur_en, pix_en, black;

  assign cur_en = !ctl[CTL_NOCUR_BIT];

  ipc_addr_gen #(.COORD_W(COORD_W), .ADDR_W(ADDR_W)) u_addr (
    .base  (top_addr),
    .width (scr_width),
    .x     (pix_x),
    .y     (pix_y),
    .addr  (calc_addr)
  );

  ipc_cursor #(.COORD_W(COORD_W), .CUR_SIZE(CUR_SIZE)) u_cursor (
    .clk      (clk),
    .pat_we   (pat_we),
    .pat_idx  (pat_idx),
    .pat_word (pat_word),
    .enable   (cur_en),
    .x        (pix_x),
    .y        (pix_y),
    .org_x    (cur_pos[2*COORD_W-1:COORD_W]),
    .org_y    (cur_pos[COORD_W-1:0]),
    .code     (calc_code)
  );

  ipc_palette #(.IDX_W(PIX_W)) u_pal (
    .clk      (clk),
    .pal_we   (pal_we),
    .pal_idx  (pal_idx),
    .pal_rgb  (pal_rgb),
    .cpal_we  (cpal_we),
    .cpal_idx (cpal_idx),
    .cpal_rgb (cpal_rgb),
    .rd_idx   (fb_data),
    .rd_code  (s1_code_q),
    .rgb      (lut_rgb)
  );

  // next state
  always_comb begin
    pix_en    = pix_valid;
    s1_v_d    = pix_valid;
    s1_x_d    = s1_x_q;
    s1_y_d    = s1_y_q;
    s1_code_d = s1_code_q;
    s1_last_d = 1'b0;
    addr_d    = addr_q;
    if (pix_en) begin
      s1_x_d    = pix_x;
      s1_y_d    = pix_y;
      s1_code_d = calc_code;
      addr_d    = calc_addr;
      s1_last_d = (pix_x == scr_width - 1'b1) && (pix_y == scr_height - 1'b1);
    end

    black   = ctl[CTL_BLANK_BIT] ||
              (ctl[CTL_DEPTH_LSB +: 3] != DEPTH_IDX8) || !s1_v_q;
    o_v_d   = s1_v_q;
    o_x_d   = s1_v_q ? s1_x_q : out_x;
    o_y_d   = s1_v_q ? s1_y_q : out_y;
    o_rgb_d = black ? '0 : lut_rgb;

    irq_d = frame_irq;
    if (host_wr) irq_d = 1'b0;
    if (s1_v_q && s1_last_q) irq_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v_q    <= 1'b0;
      s1_x_q    <= '0;
      s1_y_q    <= '0;
      s1_code_q <= '0;
      s1_last_q <= 1'b0;
      addr_q    <= '0;
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      out_rgb   <= '0;
      frame_irq <= 1'b0;
    end else begin
      s1_v_q    <= s1_v_d;
      s1_x_q    <= s1_x_d;
      s1_y_q    <= s1_y_d;
      s1_code_q <= s1_code_d;
      s1_last_q <= s1_last_d;
      addr_q    <= addr_d;
      out_valid <= o_v_d;
      out_x     <= o_x_d;
      out_y     <= o_y_d;
      out_rgb   <= o_rgb_d;
      frame_irq <= irq_d;
    end
  end

  assign fb_rd   = s1_v_q;
  assign fb_addr = addr_q;
endmodule

// File: rtl/ipc_checker.sv
module ipc_checker #(
  parameter int COORD_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pix_valid,
  input logic [COORD_W-1:0] pix_x,
  input logic [COORD_W-1:0] pix_y,
  input logic [31:0]        ctl,
  input logic               host_wr,
  input logic               fb_rd,
  input logic               out_valid,
  input logic [COORD_W-1:0] out_x,
  input logic [COORD_W-1:0] out_y,
  input logic [23:0]        out_rgb,
  input logic               frame_irq
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_valid_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (out_valid == $past(pix_valid, 2)));

  p_coord_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && out_valid) |-> (out_x == $past(pix_x, 2) && out_y == $past(pix_y, 2)));

  p_read_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd1) |-> (fb_rd == $past(pix_valid)));

  p_blank_black_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[10] |=> (out_rgb == 24'h0));

  p_depth_black_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[22:20] != 3'd3) |=> (out_rgb == 24'h0));

  p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> (!frame_irq || out_valid));

  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_irq && !host_wr) |=> frame_irq);

  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_irq) |-> out_valid);
endmodule

bind idxpix_cursor_pipe ipc_checker #(.COORD_W(COORD_W)) u_ipc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .pix_valid (pix_valid),
  .pix_x     (pix_x),
  .pix_y     (pix_y),
  .ctl       (ctl),
  .host_wr   (host_wr),
  .fb_rd     (fb_rd),
  .out_valid (out_valid),
  .out_x     (out_x),
  .out_y     (out_y),
  .out_rgb   (out_rgb),
  .frame_irq (frame_irq)
);

// File: tb/idxpix_cursor_pipe_bench.sv
module idxpix_cursor_pipe_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pix_valid;
  logic [11:0] pix_x, pix_y;
  logic        fb_rd;
  logic [23:0] fb_addr;
  logic [7:0]  fb_data;
  logic [31:0] ctl;
  logic [23:0] cur_pos;
  logic [23:0] top_addr;
  logic [11:0] scr_width, scr_height;
  logic        pal_we;
  logic [7:0]  pal_idx;
  logic [23:0] pal_rgb;
  logic        cpal_we;
  logic [1:0]  cpal_idx;
  logic [23:0] cpal_rgb;
  logic        pat_we;
  logic [8:0]  pat_idx;
  logic [15:0] pat_word;
  logic        host_wr;
  logic        out_valid;
  logic [11:0] out_x, out_y;
  logic [23:0] out_rgb;
  logic        frame_irq;

  int checks = 0;
  int errors = 0;
  bit summary_done = 0;

  logic [7:0]  vmem  [4096];
  logic [23:0] bpal  [256];
  logic [23:0] bcpal [3];
  logic [15:0] bpat  [512];

  always #4 clk = ~clk;

  assign fb_data = vmem[fb_addr[11:0]];

  idxpix_cursor_pipe u_idxpix_cursor_pipe (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [23:0] model_rgb(int x, int y);
    int a, cx, cy, dx, dy;
    logic [15:0] w;
    logic [1:0] code;
    if (ctl[10]) return 24'h0;
    if (ctl[22:20] != 3'd3) return 24'h0;
    a  = (int'(top_addr) + y * int'(scr_width) + x) & 4095;
    cx = int'(cur_pos[23:12]);
    cy = int'(cur_pos[11:0]);
    if (!ctl[23] && y >= cy && y < cy + 64 && x >= cx && x < cx + 64) begin
      dx = x - cx;
      dy = y - cy;
      w = bpat[dy * 8 + dx / 8];
      code = 2'(w >> ((dx % 8) * 2));
      if (code != 2'd0) return bcpal[code - 1];
    end
    return bpal[vmem[a]];
  endfunction

  function automatic logic [23:0] model_addr(int x, int y);
    return 24'(int'(top_addr) + y * int'(scr_width) + x);
  endfunction

  task automatic write_pat(int i, logic [15:0] w);
    @(negedge clk);
    pat_we = 1; pat_idx = 9'(i); pat_word = w; bpat[i] = w;
    @(negedge clk);
    pat_we = 0;
  endtask

  // drive one pixel, check address one edge later and color two edges later
  task automatic probe(int x, int y, string req);
    logic [23:0] ea, er;
    ea = model_addr(x, y);
    er = model_rgb(x, y);
    @(negedge clk);
    pix_valid = 1; pix_x = 12'(x); pix_y = 12'(y);
    @(negedge clk);
    pix_valid = 0;
    if (req == "R2") begin
      check("R2 fb_rd", 32'(fb_rd), 32'd1);
      check("R2 fb_addr", 32'(fb_addr), 32'(ea));
    end
    @(negedge clk);
    check(req, 32'(out_rgb), 32'(er));
  endtask

  task automatic t_reset();
    check("R11 out_valid", 32'(out_valid), 0);
    check("R11 fb_rd", 32'(fb_rd), 0);
    check("R11 frame_irq", 32'(frame_irq), 0);
    check("R11 out_rgb", 32'(out_rgb), 0);
  endtask

  task automatic t_plain();
    ctl = 32'h0080_0000 | (32'd3 << 20);
    top_addr = 24'd100; scr_width = 12'd640; scr_height = 12'd480;
    probe(0, 0, "R2");
    probe(5, 3, "R2");
    probe(17, 2, "R3");
    top_addr = 24'd7; scr_width = 12'd320;
    probe(5, 3, "R2");
    probe(300, 9, "R3");
    probe(1, 1, "R3");
  endtask

  task automatic t_latency();
    @(negedge clk);
    pix_valid = 1; pix_x = 12'd10; pix_y = 12'd20;
    @(negedge clk);
    pix_x = 12'd11; pix_y = 12'd21;
    @(negedge clk);
    pix_valid = 0;
    check("R1 valid", 32'(out_valid), 1);
    check("R1 x", 32'(out_x), 10);
    check("R1 y", 32'(out_y), 20);
    @(negedge clk);
    check("R1 x2", 32'(out_x), 11);
    check("R1 y2", 32'(out_y), 21);
    @(negedge clk);
    check("R1 idle valid", 32'(out_valid), 0);
    check("R1 idle rgb", 32'(out_rgb), 0);
  endtask

  task automatic t_cursor();
    ctl = 32'd3 << 20;
    top_addr = 24'd0; scr_width = 12'd640;
    cur_pos = {12'd100, 12'd40};
    write_pat(0, 16'h00E4);
    probe(100, 40, "R6 code0");
    check("R6 code0 value", 32'(out_rgb), 32'(bpal[vmem[(40 * 640 + 100) & 4095]]));
    probe(101, 40, "R6 code1");
    check("R6 code1 value", 32'(out_rgb), 32'(bcpal[0]));
    probe(102, 40, "R6 code2");
    check("R6 code2 value", 32'(out_rgb), 32'(bcpal[1]));
    probe(103, 40, "R6 code3");
    check("R6 code3 value", 32'(out_rgb), 32'(bcpal[2]));
    for (int i = 0; i < 64; i += 5) probe(100 + i, 40 + i, "R5");
    for (int i = 0; i < 64; i += 9) probe(100 + i, 77, "R5");
  endtask

  task automatic t_window();
    write_pat(7, 16'hFFFF);
    write_pat(63 * 8, 16'hFFFF);
    write_pat(63 * 8 + 7, 16'hFFFF);
    probe(163, 40, "R4 right inside");
    check("R4 right inside value", 32'(out_rgb), 32'(bcpal[2]));
    probe(164, 40, "R4 right outside");
    probe(99, 40, "R4 left outside");
    probe(100, 103, "R4 bottom inside");
    check("R4 bottom inside value", 32'(out_rgb), 32'(bcpal[2]));
    probe(100, 104, "R4 bottom outside");
    probe(100, 39, "R4 top outside");
    // cursor near the right edge: would wrap to x=3 without clipping
    cur_pos = {12'd4090, 12'd40};
    write_pat(1, 16'hFFFF);
    probe(4091, 40, "R4 edge inside");
    check("R4 edge inside value", 32'(out_rgb), 32'(bcpal[0]));
    probe(3, 40, "R4 no wrap");
    check("R4 no wrap value", 32'(out_rgb), 32'(bpal[vmem[(40 * 640 + 3) & 4095]]));
    cur_pos = {12'd100, 12'd40};
  endtask

  task automatic t_nocursor();
    ctl = 32'h0080_0000 | (32'd3 << 20);
    probe(103, 40, "R7");
    check("R7 value", 32'(out_rgb), 32'(bpal[vmem[(40 * 640 + 103) & 4095]]));
    probe(163, 40, "R7");
  endtask

  task automatic t_blank();
    ctl = 32'h0000_0400 | (32'd3 << 20);
    probe(103, 40, "R8");
    check("R8 cursor black", 32'(out_rgb), 0);
    probe(5, 5, "R8");
    check("R8 frame black", 32'(out_rgb), 0);
  endtask

  task automatic t_depth();
    ctl = 32'd4 << 20;
    probe(5, 5, "R9");
    check("R9 depth4 black", 32'(out_rgb), 0);
    ctl = 32'd2 << 20;
    probe(103, 40, "R9");
    check("R9 depth2 black", 32'(out_rgb), 0);
    ctl = 32'd3 << 20;
    probe(5, 5, "R9");
  endtask

  task automatic t_irq();
    top_addr = 24'd0; scr_width = 12'd4; scr_height = 12'd2;
    @(negedge clk); host_wr = 1;
    @(negedge clk); host_wr = 0;
    check("R10 start low", 32'(frame_irq), 0);
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      pix_valid = 1; pix_x = 12'(p % 4); pix_y = 12'(p / 4);
    end
    @(negedge clk);
    pix_valid = 0;
    check("R10 not before last", 32'(frame_irq), 0);
    @(negedge clk);
    check("R10 set on last", 32'(frame_irq), 1);
    repeat (5) @(negedge clk);
    check("R10 holds", 32'(frame_irq), 1);
    host_wr = 1;
    @(negedge clk);
    host_wr = 0;
    check("R10 cleared", 32'(frame_irq), 0);
    // set and clear on the same edge: set wins
    @(negedge clk);
    pix_valid = 1; pix_x = 12'd3; pix_y = 12'd1;
    @(negedge clk);
    pix_valid = 0; host_wr = 1;
    @(negedge clk);
    host_wr = 0;
    check("R10 set wins", 32'(frame_irq), 1);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; pix_valid = 0; pix_x = 0; pix_y = 0;
    ctl = 0; cur_pos = 0; top_addr = 0; scr_width = 0; scr_height = 0;
    pal_we = 0; pal_idx = 0; pal_rgb = 0;
    cpal_we = 0; cpal_idx = 0; cpal_rgb = 0;
    pat_we = 0; pat_idx = 0; pat_word = 0; host_wr = 0;
    for (int i = 0; i < 4096; i++) vmem[i] = 8'((i * 7 + 3) ^ (i >> 5));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    for (int i = 0; i < 256; i++) begin
      bpal[i] = {8'(i), 8'(~i), 8'(i ^ 8'h5A)};
      pal_we = 1; pal_idx = 8'(i); pal_rgb = bpal[i];
      @(negedge clk);
    end
    pal_we = 0;
    for (int i = 0; i < 3; i++) begin
      bcpal[i] = 24'hA00000 + 24'(i * 24'h010101) + 24'h000C0C;
      cpal_we = 1; cpal_idx = 2'(i); cpal_rgb = bcpal[i];
      @(negedge clk);
    end
    cpal_we = 0;
    for (int i = 0; i < 512; i++) begin
      bpat[i] = 16'(i * 16'h2F1B) ^ 16'hA5C3;
      pat_we = 1; pat_idx = 9'(i); pat_word = bpat[i];
      @(negedge clk);
    end
    pat_we = 0;
    t_plain();
    t_latency();
    t_cursor();
    t_window();
    t_nocursor();
    t_blank();
    t_depth();
    t_irq();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule